// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a quad-bank DDR SDRAM and steps the memory's command bus through its mandatory bring-up sequence. It starts with the clock enable held low. Once a "supplies and clock are stable" flag is seen, it waits a long power-up interval. It then raises the clock enable with a NOP and issues a fixed list of commands: precharge-all, extended mode load (DLL enable), base mode load with DLL reset, precharge-all, two auto refreshes, and a final base mode load with the DLL reset cleared. A done flag then rises and stays high until reset.

All delays are clock-cycle counts taken from parameters: the power-up interval (given in microseconds and clock MHz, with a short simulation alternative), the precharge, mode-load and refresh recovery gaps, and the DLL lock interval. The mode register contents are parameters too. Every cycle that is not a command slot carries a NOP, and the block stays idle once done.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, CKE is low, the command pins {CS#,RAS#,CAS#,WE#} read 4'b0111 (NOP), and done is low.
- R2: CKE stays low until at least PWR_CYC cycles after the stable flag is first sampled high. Once high, it stays high until reset.
- R3: After CKE rises, exactly seven commands are issued, in this order: precharge-all, mode load, mode load, precharge-all, refresh, refresh, mode load.
- R4: Precharge-all is encoded as {CS#,RAS#,CAS#,WE#}=4'b0010 with address bit 10 high.
- R5: Mode loads are encoded as 4'b0000. The first targets bank 2'b01 with EXT_MODE_VAL. The second targets bank 2'b00 with MODE_VAL with bit DLL_RST_BIT set. The last targets bank 2'b00 with MODE_VAL with that bit cleared. Refresh is encoded as 4'b0001.
- R6: The first precharge-all comes one cycle after CKE rises. Each later command follows the previous one by exactly T_RP cycles after a precharge, T_MRD cycles after a mode load, and T_RFC cycles after a refresh.
- R7: Done rises no earlier than DLL_LOCK cycles after the DLL-reset mode load and no later than DLL_LOCK+3 cycles after it. It also rises no earlier than T_MRD cycles after the final mode load.
- R8: Once done is high, it stays high until reset, the command pins hold NOP, and CKE stays high.
- R9: Every cycle that is not a command slot drives NOP, and no command is issued while CKE is low.
- R10: With SIM_MODE set, the power-up wait is SIM_PWR_CYC cycles rather than PWR_US*CLK_MHZ, so CKE rises within PWR_CYC+3 cycles of the stable flag.
- R11: Once the stable flag has been seen high, dropping it later has no effect on the command stream or on done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrStable | input | 1 | Supplies and clock are stable |
| memCke | output | 1 | Memory clock enable |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBa | output | 2 | Bank address |
| memAddr | output | ADDR_W | Address bus |
| initDone | output | 1 | Initialization complete |

## Verification
A wrong state in the sequencer shows up at the command pins within one cycle, as a command out of order, one that is missing, or one that is repeated. A fault in the shared gap counter shows up as a spacing error at the very next command, so the bench records the cycle of every command and compares each gap with its parameter. A fault in the DLL lock counter shows up only at done, so the bench bounds the done cycle against the DLL-reset command from both sides. Several stable-flag delays are swept, and some runs drop the flag partway through.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  typedef enum logic [2:0] {
    CMD_NOP, CMD_PRE, CMD_EMRS, CMD_MRS_RST, CMD_MRS_RUN, CMD_REF
  } cmdSel_e;

  typedef enum logic [2:0] {
    LD_NONE, LD_PWR, LD_RP, LD_MRD, LD_RFC
  } loadSel_e;

  typedef struct packed {
    cmdSel_e  cmd;
    loadSel_e load;
    logic     ckeOn;
    logic     lockStart;
    logic     setDone;
  } strobe_t;

  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_MRS = 4'b0000;
  localparam logic [3:0] PIN_REF = 4'b0001;
endpackage

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwrStable,
  input  logic    cntLast,
  input  logic    lockDone,
  output strobe_t strobe
);
  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_CKE, S_PRE1, S_W1, S_EMRS, S_W2, S_MRS1, S_W3,
    S_PRE2, S_W4, S_REF1, S_W5, S_REF2, S_W6, S_MRS2, S_W7, S_LOCK, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '{cmd: CMD_NOP, load: LD_NONE, ckeOn: 1'b0,
                  lockStart: 1'b0, setDone: 1'b0};
    case (state)
      S_IDLE: if (pwrStable) begin strobe.load = LD_PWR; nextState = S_PWR; end
      S_PWR:  if (cntLast) nextState = S_CKE;
      S_CKE:  begin strobe.ckeOn = 1'b1; nextState = S_PRE1; end
      S_PRE1: begin strobe.cmd = CMD_PRE; strobe.load = LD_RP; nextState = S_W1; end
      S_W1:   if (cntLast) nextState = S_EMRS;
      S_EMRS: begin strobe.cmd = CMD_EMRS; strobe.load = LD_MRD; nextState = S_W2; end
      S_W2:   if (cntLast) nextState = S_MRS1;
      S_MRS1: begin
        strobe.cmd = CMD_MRS_RST; strobe.load = LD_MRD;
        strobe.lockStart = 1'b1; nextState = S_W3;
      end
      S_W3:   if (cntLast) nextState = S_PRE2;
      S_PRE2: begin strobe.cmd = CMD_PRE; strobe.load = LD_RP; nextState = S_W4; end
      S_W4:   if (cntLast) nextState = S_REF1;
      S_REF1: begin strobe.cmd = CMD_REF; strobe.load = LD_RFC; nextState = S_W5; end
      S_W5:   if (cntLast) nextState = S_REF2;
      S_REF2: begin strobe.cmd = CMD_REF; strobe.load = LD_RFC; nextState = S_W6; end
      S_W6:   if (cntLast) nextState = S_MRS2;
      S_MRS2: begin strobe.cmd = CMD_MRS_RUN; strobe.load = LD_MRD; nextState = S_W7; end
      S_W7:   if (cntLast) nextState = S_LOCK;
      S_LOCK: if (lockDone) nextState = S_DONE;
      S_DONE: strobe.setDone = 1'b1;
      default: nextState = S_IDLE;
    endcase
  end

  // R7: the block only finishes once the DLL lock window has elapsed
  p_lock_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE) |-> lockDone);

  // R8: once finished the controller never leaves the done state
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE) |=> (state == S_DONE));
endmodule

// File: rtl/ddr_init_dp.sv
module ddr_init_dp
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int PWR_CYC      = 40000,
  parameter int T_RP         = 3,
  parameter int T_MRD        = 2,
  parameter int T_RFC        = 15,
  parameter int DLL_LOCK     = 200,
  parameter int DLL_RST_BIT  = 8,
  parameter int PALL_BIT     = 10,
  parameter logic [ADDR_W-1:0] EXT_MODE_VAL = '0,
  parameter logic [ADDR_W-1:0] MODE_VAL     = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output logic              cntLast,
  output logic              lockDone,
  output logic              memCke,
  output logic [3:0]        cmdPins,
  output logic [1:0]        memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone
);
  localparam int MAX_GAP = (PWR_CYC > T_RFC) ? PWR_CYC : T_RFC;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);
  localparam int LOCK_W  = $clog2(DLL_LOCK + 1);
  localparam logic [ADDR_W-1:0] RST_MASK = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] PALL_A   = ADDR_W'(1) << PALL_BIT;

  logic [CNT_W-1:0]  gapCnt;
  logic [LOCK_W-1:0] lockCnt;
  logic [CNT_W-1:0]  loadVal;

  always_comb begin
    case (strobe.load)
      LD_PWR:  loadVal = CNT_W'(PWR_CYC - 1);
      LD_RP:   loadVal = CNT_W'(T_RP - 1);
      LD_MRD:  loadVal = CNT_W'(T_MRD - 1);
      LD_RFC:  loadVal = CNT_W'(T_RFC - 1);
      default: loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      gapCnt <= '0;
    else if (strobe.load != LD_NONE) gapCnt <= loadVal;
    else if (gapCnt != '0)          gapCnt <= gapCnt - 1'b1;
  end
  assign cntLast = (gapCnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)                                     lockCnt <= '0;
    else if (strobe.lockStart)                     lockCnt <= LOCK_W'(1);
    else if (lockCnt != '0 && !lockDone)           lockCnt <= lockCnt + 1'b1;
  end
  assign lockDone = (lockCnt >= LOCK_W'(DLL_LOCK));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCke   <= 1'b0;
      cmdPins  <= PIN_NOP;
      memBa    <= 2'b00;
      memAddr  <= '0;
      initDone <= 1'b0;
    end else begin
      if (strobe.ckeOn)   memCke   <= 1'b1;
      if (strobe.setDone) initDone <= 1'b1;
      case (strobe.cmd)
        CMD_PRE:     begin cmdPins <= PIN_PRE; memBa <= 2'b00; memAddr <= PALL_A; end
        CMD_EMRS:    begin cmdPins <= PIN_MRS; memBa <= 2'b01; memAddr <= EXT_MODE_VAL; end
        CMD_MRS_RST: begin cmdPins <= PIN_MRS; memBa <= 2'b00; memAddr <= MODE_VAL | RST_MASK; end
        CMD_MRS_RUN: begin cmdPins <= PIN_MRS; memBa <= 2'b00; memAddr <= MODE_VAL & ~RST_MASK; end
        CMD_REF:     begin cmdPins <= PIN_REF; memBa <= 2'b00; memAddr <= '0; end
        default:     begin cmdPins <= PIN_NOP; memBa <= 2'b00; memAddr <= '0; end
      endcase
    end
  end

  // R2: clock enable never falls once raised
  p_cke_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    memCke |=> memCke);
  // R9: nothing but NOP while clock enable is low
  p_nop_when_cke_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !memCke |-> (cmdPins == PIN_NOP));
  // R8: done is sticky and the bus is quiet after it
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (cmdPins == PIN_NOP && memCke));
  // R7: done rises only after the lock window
  p_done_after_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> lockDone);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int CLK_MHZ     = 200,
  parameter int PWR_US      = 200,
  parameter bit SIM_MODE    = 1'b0,
  parameter int SIM_PWR_CYC = 20,
  parameter int T_RP        = 3,
  parameter int T_MRD       = 2,
  parameter int T_RFC       = 15,
  parameter int DLL_LOCK    = 200,
  parameter int DLL_RST_BIT = 8,
  parameter logic [ADDR_W-1:0] EXT_MODE_VAL = '0,
  parameter logic [ADDR_W-1:0] MODE_VAL     = ADDR_W'(13'h0062)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrStable,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [1:0]        memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone
);
  localparam int PWR_CYC = SIM_MODE ? SIM_PWR_CYC : PWR_US * CLK_MHZ;

  strobe_t    strobe;
  logic       cntLast, lockDone;
  logic [3:0] cmdPins;

  ddr_init_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwrStable(pwrStable),
    .cntLast(cntLast), .lockDone(lockDone), .strobe(strobe)
  );

  ddr_init_dp #(
    .ADDR_W(ADDR_W), .PWR_CYC(PWR_CYC), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .DLL_LOCK(DLL_LOCK), .DLL_RST_BIT(DLL_RST_BIT),
    .PALL_BIT(10), .EXT_MODE_VAL(EXT_MODE_VAL), .MODE_VAL(MODE_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntLast(cntLast),
    .lockDone(lockDone), .memCke(memCke), .cmdPins(cmdPins),
    .memBa(memBa), .memAddr(memAddr), .initDone(initDone)
  );

  assign {memCsN, memRasN, memCasN, memWeN} = cmdPins;
endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int PWR    = 20;
  localparam int TRP    = 3;
  localparam int TMRD   = 2;
  localparam int TRFC   = 9;
  localparam int LOCK   = 200;
  localparam int RSTBIT = 8;
  localparam logic [ADDR_W-1:0] EMR = 13'h0000;
  localparam logic [ADDR_W-1:0] MR  = 13'h0062;

  logic clk = 1'b0, rstN = 1'b0, pwrStable = 1'b0;
  logic memCke, memCsN, memRasN, memCasN, memWeN, initDone;
  logic [1:0] memBa;
  logic [ADDR_W-1:0] memAddr;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(ADDR_W), .SIM_MODE(1'b1), .SIM_PWR_CYC(PWR), .T_RP(TRP),
    .T_MRD(TMRD), .T_RFC(TRFC), .DLL_LOCK(LOCK), .DLL_RST_BIT(RSTBIT),
    .EXT_MODE_VAL(EMR), .MODE_VAL(MR)
  ) u_ddr_init_seq (
    .clk(clk), .rstN(rstN), .pwrStable(pwrStable), .memCke(memCke),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memBa(memBa), .memAddr(memAddr), .initDone(initDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOnce(input int dly, input bit glitch);
    int kind[16]; int at[16]; int bas[16]; int adr[16];
    int nCmd = 0, stableK = -1, ckeRise = -1, doneK = -1;
    int badCode = 0, ckeDrop = 0, doneDrop = 0, busyAfterDone = 0, cmdCkeLow = 0;
    logic [3:0] pins;
    rstN = 1'b0; pwrStable = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(memCke == 1'b0, "R1 cke", int'(memCke), 0);
    chk({memCsN, memRasN, memCasN, memWeN} == 4'b0111, "R1 nop",
        int'({memCsN, memRasN, memCasN, memWeN}), 7);
    chk(initDone == 1'b0, "R1 done", int'(initDone), 0);
    rstN = 1'b1;
    for (int k = 0; k < 800; k++) begin
      @(negedge clk);
      pins = {memCsN, memRasN, memCasN, memWeN};
      if (ckeRise >= 0 && !memCke) ckeDrop++;
      if (ckeRise < 0 && memCke) ckeRise = k;
      if (doneK >= 0 && !initDone) doneDrop++;
      if (doneK >= 0 && (pins != 4'b0111 || !memCke)) busyAfterDone++;
      if (doneK < 0 && initDone) doneK = k;
      if (pins != 4'b0111) begin
        if (!memCke) cmdCkeLow++;
        if (pins == 4'b0010 || pins == 4'b0000 || pins == 4'b0001) begin
          if (nCmd < 16) begin
            kind[nCmd] = (pins == 4'b0010) ? 1 : (pins == 4'b0000) ? 2 : 3;
            at[nCmd] = k; bas[nCmd] = int'(memBa); adr[nCmd] = int'(memAddr);
          end
          nCmd++;
        end else badCode++;
      end
      if (k == dly) begin pwrStable = 1'b1; stableK = k; end
      if (glitch && k == dly + 6) pwrStable = 1'b0;   // R11 stimulus
      if (doneK >= 0 && k > doneK + 20) break;
    end
    chk(ckeRise - stableK >= PWR, "R2 cke wait", ckeRise - stableK, PWR);
    chk(ckeDrop == 0, "R2 cke hold", ckeDrop, 0);
    chk(ckeRise - stableK <= PWR + 3, "R10 short wait", ckeRise - stableK, PWR + 3);
    chk(nCmd == 7, glitch ? "R11 R3 count" : "R3 count", nCmd, 7);
    if (nCmd == 7) begin
      chk(kind[0] == 1 && kind[1] == 2 && kind[2] == 2 && kind[3] == 1 &&
          kind[4] == 3 && kind[5] == 3 && kind[6] == 2, "R3 order",
          kind[0]*1000000 + kind[1]*100000 + kind[2]*10000 + kind[3]*1000 +
          kind[4]*100 + kind[5]*10 + kind[6], 1221332);
      chk(adr[0][10] && adr[3][10], "R4 pall bit", adr[0], 1024);
      chk(bas[1] == 1 && adr[1] == int'(EMR), "R5 ext load", adr[1], int'(EMR));
      chk(bas[2] == 0 && adr[2] == (int'(MR) | (1 << RSTBIT)), "R5 dll reset load",
          adr[2], int'(MR) | (1 << RSTBIT));
      chk(bas[6] == 0 && adr[6] == (int'(MR) & ~(1 << RSTBIT)), "R5 run load",
          adr[6], int'(MR) & ~(1 << RSTBIT));
      chk(at[0] - ckeRise == 1, "R6 pre after cke", at[0] - ckeRise, 1);
      chk(at[1] - at[0] == TRP, "R6 trp 1", at[1] - at[0], TRP);
      chk(at[2] - at[1] == TMRD, "R6 tmrd 1", at[2] - at[1], TMRD);
      chk(at[3] - at[2] == TMRD, "R6 tmrd 2", at[3] - at[2], TMRD);
      chk(at[4] - at[3] == TRP, "R6 trp 2", at[4] - at[3], TRP);
      chk(at[5] - at[4] == TRFC, "R6 trfc 1", at[5] - at[4], TRFC);
      chk(at[6] - at[5] == TRFC, "R6 trfc 2", at[6] - at[5], TRFC);
      chk(doneK - at[2] >= LOCK && doneK - at[2] <= LOCK + 3, "R7 lock window",
          doneK - at[2], LOCK);
      chk(doneK - at[6] >= TMRD, "R7 after last load", doneK - at[6], TMRD);
    end
    chk(doneK >= 0 && doneDrop == 0, "R8 done hold", doneDrop, 0);
    chk(busyAfterDone == 0, "R8 quiet", busyAfterDone, 0);
    chk(badCode == 0 && cmdCkeLow == 0, "R9 nop filler", badCode + cmdCkeLow, 0);
  endtask

  initial begin
    runOnce(0, 1'b0);
    runOnce(1, 1'b0);
    runOnce(2, 1'b1);
    runOnce(5, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule